// File: doc/BRIEF.md
# PCI Single-Function Configuration Space with Base Address Decode

This block holds the configuration registers of a single-function PCI target and turns their contents into address-decode strobes. Configuration accesses arrive through a byte-wide port. Each access carries a function number, an 8-bit register offset, a write enable and write data. Read data comes back combinationally for the offset and function being presented. Writes take effect at the next rising clock edge.

The block holds three windows: one memory base, one I/O base and one expansion ROM base. Each byte of each base register has a write mask, so a programmed base always stays aligned to the size of its window. With the default parameters the windows are a 4096-byte memory window, a 64-port I/O window and a 32 KB ROM window. Three comparators check the incoming memory and I/O addresses against the enabled bases and raise one hit strobe per window. The vendor ID, device ID and header type are fixed by parameters.

Top module: `pcicfg_space`

## Requirements
- R1: When the function number is not 0, a read returns 0xFF. A write with a nonzero function number changes no register.
- R2: The command register at offset 0x04 keeps only bit 0 (I/O decode enable) and bit 1 (memory decode enable). All other bits read as 0.
- R3: The memory base occupies offsets 0x10–0x13. Offset 0x10 always reads 0. Offset 0x11 keeps only bits 7:4. Offsets 0x12 and 0x13 keep all bits. The resulting base is a multiple of 4096.
- R4: The I/O base occupies offsets 0x14–0x17. At offset 0x14 only bits 7:6 are writable, and bits 5:0 always read 0x01 (bit 0 set marks an I/O base). Offset 0x15 keeps all bits. Offsets 0x16 and 0x17 read 0 and ignore writes.
- R5: `io_hit` is 1 only when all three of the following hold: command bit 0 is set; the base formed from 0x15:0x14 with bits 5:0 cleared is nonzero; and `io_addr` with bits 5:0 cleared equals that base.
- R6: `mem_hit` is 1 only when command bit 1 is set and `mem_addr` with bits 11:0 cleared equals the base formed from offsets 0x13:0x11. A base of zero still decodes.
- R7: The ROM base occupies offsets 0x30–0x33. At offset 0x30 only bit 0 (ROM enable) is writable. Offset 0x31 keeps only bit 7. Offsets 0x32 and 0x33 keep all bits. The base is therefore 32 KB aligned.
- R8: `rom_hit` is 1 only when all three of the following hold: the ROM enable bit is set; command bit 1 is set; and `mem_addr` with bits 14:0 cleared equals the ROM base.
- R9: After reset, every register reads 0 except offset 0x14, which reads 0x01. All hit strobes are 0.
- R10: The following offsets are read-only and ignore writes:
  - 0x00–0x01 return the vendor ID, low byte first.
  - 0x02–0x03 return the device ID, low byte first.
  - 0x0E returns the header type.
  Any offset not named in these requirements reads 0 for function 0.
- R11: A write is seen in read data and in the decode only after the next rising clock edge. Read data and hit strobes follow their inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_func | input | 3 | Function number of the configuration access |
| cfg_off | input | 8 | Register offset of the configuration access |
| cfg_we | input | 1 | Write strobe, sampled at the rising edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the presented function and offset |
| mem_addr | input | 32 | Memory address to decode |
| io_addr | input | 16 | I/O address to decode |
| mem_hit | output | 1 | Address falls in the enabled memory window |
| io_hit | output | 1 | Address falls in the enabled I/O window |
| rom_hit | output | 1 | Address falls in the enabled ROM window |

## Verification
A corrupted base or command register would show up in two ways. The same cycle, the corrupted byte would read back wrong through the configuration port. The same cycle, a hit strobe would also fire wrongly or stay low, either for an address at the window's edge or for any address at all. A wrong write mask would leave a bit set that should read 0. That bit would move a window boundary, so addresses one step inside or outside the window would give the wrong answer. A write that leaked from a foreign function, or that landed in a lane it should not touch, would stay in the register. It would be visible on the first read of that offset after the write.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

   localparam int CFG_OFF_W  = 8;
   localparam int CFG_DATA_W = 8;

   // dword index (offset[7:2]) of each implemented register group
   typedef enum logic [5:0] {
      DW_IDENT  = 6'h00,
      DW_CMD    = 6'h01,
      DW_HDR    = 6'h03,
      DW_MEMWIN = 6'h04,
      DW_IOWIN  = 6'h05,
      DW_ROMWIN = 6'h0C
   } cfg_dword_e;

   // byte lanes of a register that stay writable when the window is 2**low_bit in size
   function automatic logic [7:0] lane_keep(input int unsigned lane, input int unsigned low_bit);
      logic [7:0] k;
      for (int b = 0; b < 8; b++) begin
         k[b] = ((lane * 8 + b) >= low_bit);
      end
      return k;
   endfunction

endpackage

// File: rtl/pcicfg_bar_lanes.sv
module pcicfg_bar_lanes #(
   parameter int unsigned         BYTES = 4,
   parameter logic [8*BYTES-1:0]  KEEP  = '1,
   parameter logic [8*BYTES-1:0]  HARD  = '0,
   localparam int unsigned        VW    = 8 * BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    lane,
   input  logic [7:0]    wdata,
   output logic [VW-1:0] value
);

   initial begin
      if (BYTES < 1 || BYTES > 4) $error("pcicfg_bar_lanes: BYTES must be 1..4");
      if ((KEEP & HARD) != '0) $error("pcicfg_bar_lanes: KEEP and HARD overlap");
   end

   logic [VW-1:0] stored;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      localparam logic [7:0] LANE_KEEP = KEEP[8*g +: 8];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stored[8*g +: 8] <= '0;
         end else if (wr_en && (lane == 2'(g))) begin
            stored[8*g +: 8] <= wdata & LANE_KEEP;
         end
      end
   end

   assign value = (stored & KEEP) | HARD;

   AST_LANE_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({30'd0, lane} >= BYTES)) |=> $stable(value)); // R4

endmodule

// File: rtl/pcicfg_regs.sv
module pcicfg_regs
   import pcicfg_pkg::*;
#(
   parameter int unsigned FUNC_W      = 3,
   parameter int unsigned MEM_LOG2    = 12,
   parameter int unsigned IO_LOG2     = 6,
   parameter int unsigned ROM_LOG2    = 15,
   parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
   parameter logic [15:0] DEVICE_ID   = 16'h7A21,
   parameter logic [7:0]  HEADER_TYPE = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FUNC_W-1:0]     cfg_func,
   input  logic [CFG_OFF_W-1:0]  cfg_off,
   input  logic                  cfg_we,
   input  logic [CFG_DATA_W-1:0] cfg_wdata,
   output logic [CFG_DATA_W-1:0] cfg_rdata,
   output logic                  cmd_io,
   output logic                  cmd_mem,
   output logic [31:0]           mem_base,
   output logic [15:0]           io_base,
   output logic [31:0]           rom_base,
   output logic                  rom_en
);

   localparam logic [31:0] MEM_KEEP = {lane_keep(3, MEM_LOG2), lane_keep(2, MEM_LOG2),
                                       lane_keep(1, MEM_LOG2), lane_keep(0, MEM_LOG2)};
   localparam logic [15:0] IO_KEEP  = {lane_keep(1, IO_LOG2), lane_keep(0, IO_LOG2)};
   localparam logic [15:0] IO_HARD  = 16'h0001;
   localparam logic [31:0] ROM_KEEP = {lane_keep(3, ROM_LOG2), lane_keep(2, ROM_LOG2),
                                       lane_keep(1, ROM_LOG2), lane_keep(0, ROM_LOG2)} | 32'h1;

   logic       own_fn;
   logic       wr_any;
   logic [5:0] dw;
   logic [1:0] lane;
   logic [1:0] cmd_q;
   logic [31:0] mem_v;
   logic [15:0] io_v;
   logic [31:0] rom_v;
   logic [31:0] rd_word;

   assign own_fn = (cfg_func == '0);
   assign wr_any = cfg_we && own_fn;
   assign dw     = cfg_off[7:2];
   assign lane   = cfg_off[1:0];

   // command register: decode enables only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_any && (dw == DW_CMD) && (lane == 2'd0)) begin
         cmd_q <= cfg_wdata[1:0];
      end
   end

   pcicfg_bar_lanes #(.BYTES(4), .KEEP(MEM_KEEP), .HARD(32'h0)) i_mem_lanes (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_any && (dw == DW_MEMWIN)),
      .lane  (lane),
      .wdata (cfg_wdata),
      .value (mem_v)
   );

   pcicfg_bar_lanes #(.BYTES(2), .KEEP(IO_KEEP), .HARD(IO_HARD)) i_io_lanes (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_any && (dw == DW_IOWIN)),
      .lane  (lane),
      .wdata (cfg_wdata),
      .value (io_v)
   );

   pcicfg_bar_lanes #(.BYTES(4), .KEEP(ROM_KEEP), .HARD(32'h0)) i_rom_lanes (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_any && (dw == DW_ROMWIN)),
      .lane  (lane),
      .wdata (cfg_wdata),
      .value (rom_v)
   );

   always_comb begin
      unique case (dw)
         DW_IDENT:  rd_word = {DEVICE_ID, VENDOR_ID};
         DW_CMD:    rd_word = {30'd0, cmd_q};
         DW_HDR:    rd_word = {8'h00, HEADER_TYPE, 16'h0000};
         DW_MEMWIN: rd_word = mem_v;
         DW_IOWIN:  rd_word = {16'h0000, io_v};
         DW_ROMWIN: rd_word = rom_v;
         default:   rd_word = '0;
      endcase
   end

   assign cfg_rdata = own_fn ? rd_word[8*lane +: 8] : 8'hFF;

   assign cmd_io   = cmd_q[0];
   assign cmd_mem  = cmd_q[1];
   assign mem_base = mem_v;
   assign io_base  = io_v;
   assign rom_base = {rom_v[31:1], 1'b0};
   assign rom_en   = rom_v[0];

   AST_FOREIGN_FUNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_func != '0)) |=> ($stable(cmd_q) && $stable(mem_v) && $stable(io_v) && $stable(rom_v))); // R1

   AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_func == '0) && (cfg_off == 8'h04)) |=> ({cmd_mem, cmd_io} == $past(cfg_wdata[1:0]))); // R2

   AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_base & ~MEM_KEEP) == 32'h0); // R3

endmodule

// File: rtl/pcicfg_window.sv
module pcicfg_window #(
   parameter int unsigned AW            = 32,
   parameter int unsigned SIZE_LOG2     = 12,
   parameter bit          NONZERO_GUARD = 1'b0
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic          enable,
   output logic          hit
);

   initial begin
      if (SIZE_LOG2 >= AW) $error("pcicfg_window: window wider than address");
   end

   localparam logic [AW-1:0] HI_MASK = ~((AW'(1) << SIZE_LOG2) - AW'(1));

   logic match;
   assign match = ((addr & HI_MASK) == (base & HI_MASK));

   if (NONZERO_GUARD) begin : g_guarded
      assign hit = enable && match && ((base & HI_MASK) != '0);
   end else begin : g_plain
      assign hit = enable && match;
   end

endmodule

// File: rtl/pcicfg_space.sv
module pcicfg_space #(
   parameter int unsigned FUNC_W      = 3,
   parameter int unsigned MEM_LOG2    = 12,
   parameter int unsigned IO_LOG2     = 6,
   parameter int unsigned ROM_LOG2    = 15,
   parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
   parameter logic [15:0] DEVICE_ID   = 16'h7A21,
   parameter logic [7:0]  HEADER_TYPE = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUNC_W-1:0] cfg_func,
   input  logic [7:0]        cfg_off,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [31:0]       mem_addr,
   input  logic [15:0]       io_addr,
   output logic              mem_hit,
   output logic              io_hit,
   output logic              rom_hit
);

   initial begin
      if (FUNC_W < 1) $error("pcicfg_space: FUNC_W must be at least 1");
      if (MEM_LOG2 < 4 || MEM_LOG2 > 31) $error("pcicfg_space: MEM_LOG2 out of range 4..31");
      if (IO_LOG2 < 2 || IO_LOG2 > 15) $error("pcicfg_space: IO_LOG2 out of range 2..15");
      if (ROM_LOG2 < 11 || ROM_LOG2 > 31) $error("pcicfg_space: ROM_LOG2 out of range 11..31");
   end

   logic        cmd_io;
   logic        cmd_mem;
   logic        rom_en;
   logic [31:0] mem_base;
   logic [15:0] io_base;
   logic [31:0] rom_base;

   pcicfg_regs #(
      .FUNC_W      (FUNC_W),
      .MEM_LOG2    (MEM_LOG2),
      .IO_LOG2     (IO_LOG2),
      .ROM_LOG2    (ROM_LOG2),
      .VENDOR_ID   (VENDOR_ID),
      .DEVICE_ID   (DEVICE_ID),
      .HEADER_TYPE (HEADER_TYPE)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_func  (cfg_func),
      .cfg_off   (cfg_off),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cmd_io    (cmd_io),
      .cmd_mem   (cmd_mem),
      .mem_base  (mem_base),
      .io_base   (io_base),
      .rom_base  (rom_base),
      .rom_en    (rom_en)
   );

   pcicfg_window #(.AW(32), .SIZE_LOG2(MEM_LOG2), .NONZERO_GUARD(1'b0)) i_mem_win (
      .addr   (mem_addr),
      .base   (mem_base),
      .enable (cmd_mem),
      .hit    (mem_hit)
   );

   pcicfg_window #(.AW(16), .SIZE_LOG2(IO_LOG2), .NONZERO_GUARD(1'b1)) i_io_win (
      .addr   (io_addr),
      .base   (io_base),
      .enable (cmd_io),
      .hit    (io_hit)
   );

   pcicfg_window #(.AW(32), .SIZE_LOG2(ROM_LOG2), .NONZERO_GUARD(1'b0)) i_rom_win (
      .addr   (mem_addr),
      .base   (rom_base),
      .enable (cmd_mem && rom_en),
      .hit    (rom_hit)
   );

   AST_IO_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      io_hit |-> (cmd_io && ((io_base >> IO_LOG2) != 16'h0))); // R5

   AST_MEM_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_hit |-> cmd_mem); // R6

   AST_ROM_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rom_hit |-> (cmd_mem && rom_en)); // R8

endmodule

// File: tb/test_pcicfg_space.sv
module test_pcicfg_space;

   localparam int          CLK_PERIOD = 10;
   localparam int unsigned SEED       = 32'd20517;
   localparam logic [15:0] VID        = 16'h1D0F;
   localparam logic [15:0] DID        = 16'h7A21;
   localparam logic [7:0]  HDR        = 8'h00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_func = '0;
   logic [7:0]  cfg_off = '0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [31:0] mem_addr = '0;
   logic [15:0] io_addr = '0;
   logic        mem_hit, io_hit, rom_hit;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] m [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   pcicfg_space i_pcicfg_space (
      .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_off(cfg_off),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_addr(mem_addr), .io_addr(io_addr),
      .mem_hit(mem_hit), .io_hit(io_hit), .rom_hit(rom_hit)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m[i] = 8'h00;
      m[8'h14] = 8'h01;
   endtask

   task automatic model_wr(input logic [7:0] off, input logic [7:0] v);
      case (off)
         8'h04: m[off] = v & 8'h03;
         8'h11: m[off] = v & 8'hF0;
         8'h12, 8'h13, 8'h15, 8'h32, 8'h33: m[off] = v;
         8'h14: m[off] = (v & 8'hC0) | 8'h01;
         8'h30: m[off] = v & 8'h01;
         8'h31: m[off] = v & 8'h80;
         default: ;
      endcase
   endtask

   function automatic logic [7:0] exp_rd(input logic [2:0] f, input logic [7:0] off);
      if (f != 3'd0) return 8'hFF;
      case (off)
         8'h00: return VID[7:0];
         8'h01: return VID[15:8];
         8'h02: return DID[7:0];
         8'h03: return DID[15:8];
         8'h0E: return HDR;
         default: return m[off];
      endcase
   endfunction

   function automatic logic [31:0] mbase();
      return {m[8'h13], m[8'h12], m[8'h11], 8'h00};
   endfunction
   function automatic logic [15:0] ibase();
      return {m[8'h15], m[8'h14] & 8'hC0};
   endfunction
   function automatic logic [31:0] rbase();
      return {m[8'h33], m[8'h32], m[8'h31] & 8'h80, 8'h00};
   endfunction

   function automatic logic exp_mem(input logic [31:0] a);
      return m[8'h04][1] && ((a & 32'hFFFFF000) == mbase());
   endfunction
   function automatic logic exp_io(input logic [15:0] a);
      return m[8'h04][0] && (ibase() != 16'h0) && ((a & 16'hFFC0) == ibase());
   endfunction
   function automatic logic exp_rom(input logic [31:0] a);
      return m[8'h30][0] && m[8'h04][1] && ((a & 32'hFFFF8000) == rbase());
   endfunction

   task automatic wr(input logic [2:0] f, input logic [7:0] off, input logic [7:0] v);
      @(negedge clk);
      cfg_func = f; cfg_off = off; cfg_wdata = v; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      if (f == 3'd0) model_wr(off, v);
   endtask

   task automatic rd_chk(input string req, input logic [2:0] f, input logic [7:0] off);
      cfg_func = f; cfg_off = off;
      #1;
      check(req, {24'd0, cfg_rdata}, {24'd0, exp_rd(f, off)});
   endtask

   task automatic hit_chk(input string req, input logic [31:0] ma, input logic [15:0] ia);
      mem_addr = ma; io_addr = ia;
      #1;
      check({req, " mem_hit"}, {31'd0, mem_hit}, {31'd0, exp_mem(ma)});
      check({req, " io_hit"},  {31'd0, io_hit},  {31'd0, exp_io(ia)});
      check({req, " rom_hit"}, {31'd0, rom_hit}, {31'd0, exp_rom(ma)});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] seed_sink;
      seed_sink = $urandom(SEED);
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset contents and quiet decode
      foreach (m[i]) if (i >= 8'h04 && i <= 8'h3F) rd_chk("R9 reset value", 3'd0, 8'(i));
      check("R9 io flag byte", {24'd0, exp_rd(0, 8'h14)}, 32'h01);
      hit_chk("R9 after reset", 32'h0, 16'h0);

      // R10: identity and unimplemented offsets
      for (int i = 0; i < 4; i++) rd_chk("R10 id bytes", 3'd0, 8'(i));
      rd_chk("R10 header type", 3'd0, 8'h0E);
      wr(3'd0, 8'h00, 8'h55);
      wr(3'd0, 8'h3C, 8'hA5);
      rd_chk("R10 vendor write ignored", 3'd0, 8'h00);
      rd_chk("R10 unimplemented reads 0", 3'd0, 8'h3C);

      // R1: foreign function
      wr(3'd1, 8'h12, 8'hAB);
      wr(3'd5, 8'h04, 8'h03);
      rd_chk("R1 foreign write dropped", 3'd0, 8'h12);
      rd_chk("R1 foreign write dropped cmd", 3'd0, 8'h04);
      rd_chk("R1 foreign read FF", 3'd2, 8'h00);
      rd_chk("R1 foreign read FF", 3'd7, 8'h12);

      // R11: value unchanged before the edge, changed after
      @(negedge clk);
      cfg_func = 3'd0; cfg_off = 8'h04; cfg_wdata = 8'hFF; cfg_we = 1'b1;
      #1;
      check("R11 before edge", {24'd0, cfg_rdata}, 32'h00);
      @(negedge clk);
      cfg_we = 1'b0;
      model_wr(8'h04, 8'hFF);
      rd_chk("R2 command masked", 3'd0, 8'h04);
      check("R2 command value", {24'd0, exp_rd(0, 8'h04)}, 32'h03);

      // R3: memory base masks
      for (int i = 8'h10; i <= 8'h13; i++) wr(3'd0, 8'(i), 8'hFF);
      for (int i = 8'h10; i <= 8'h13; i++) rd_chk("R3 mem base mask", 3'd0, 8'(i));

      // R4: I/O base masks, upper lanes ignored
      wr(3'd0, 8'h14, 8'hFE);
      wr(3'd0, 8'h15, 8'h12);
      wr(3'd0, 8'h16, 8'h77);
      wr(3'd0, 8'h17, 8'h88);
      for (int i = 8'h14; i <= 8'h17; i++) rd_chk("R4 io base mask", 3'd0, 8'(i));

      // R6 and R5: window edges
      wr(3'd0, 8'h11, 8'h30);
      wr(3'd0, 8'h12, 8'h00);
      wr(3'd0, 8'h13, 8'hC0);
      hit_chk("R6 R5 inside low edge", 32'hC0003000, 16'h12C0);
      hit_chk("R6 R5 inside high edge", 32'hC0003FFF, 16'h12FF);
      hit_chk("R6 R5 just below", 32'hC0002FFF, 16'h12BF);
      hit_chk("R6 R5 just above", 32'hC0004000, 16'h1300);
      wr(3'd0, 8'h04, 8'h00);
      hit_chk("R6 R5 disabled by command", 32'hC0003000, 16'h12C0);
      wr(3'd0, 8'h04, 8'h01);
      wr(3'd0, 8'h14, 8'h00);
      wr(3'd0, 8'h15, 8'h00);
      hit_chk("R5 zero io base never hits", 32'h0, 16'h0010);

      // R7 and R8: ROM base
      wr(3'd0, 8'h30, 8'hFF);
      wr(3'd0, 8'h31, 8'hFF);
      wr(3'd0, 8'h32, 8'h0E);
      wr(3'd0, 8'h33, 8'h00);
      for (int i = 8'h30; i <= 8'h33; i++) rd_chk("R7 rom base mask", 3'd0, 8'(i));
      hit_chk("R8 rom needs memory enable", 32'h000E8000, 16'h0);
      wr(3'd0, 8'h04, 8'h02);
      hit_chk("R8 rom inside", 32'h000EFFFF, 16'h0);
      hit_chk("R8 rom below", 32'h000E7FFF, 16'h0);
      wr(3'd0, 8'h30, 8'h00);
      hit_chk("R8 rom disabled", 32'h000E8000, 16'h0);

      // random mix
      for (int it = 0; it < 600; it++) begin
         logic [7:0] offs [20];
         logic [7:0] off;
         logic [2:0] f;
         offs = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h04, 8'h0E, 8'h10, 8'h11, 8'h12, 8'h13,
                  8'h14, 8'h15, 8'h16, 8'h17, 8'h30, 8'h31, 8'h32, 8'h33, 8'h3C, 8'h05};
         off = ($urandom % 8 == 0) ? 8'($urandom) : offs[$urandom % 20];
         f   = ($urandom % 6 == 0) ? 3'($urandom) : 3'd0;
         wr(f, off, 8'($urandom));
         rd_chk("R1 R2 R3 R4 R7 R10 random read", ($urandom % 6 == 0) ? 3'($urandom) : 3'd0,
                offs[$urandom % 20]);
         begin
            logic [31:0] ma;
            logic [15:0] ia;
            case ($urandom % 3)
               0: ma = mbase() | ($urandom & 32'h0000_1FFF);
               1: ma = rbase() | ($urandom & 32'h0000_FFFF);
               default: ma = $urandom;
            endcase
            ia = ($urandom % 2 == 0) ? (ibase() | 16'($urandom & 32'h7F)) : 16'($urandom);
            hit_chk("R5 R6 R8 random decode", ma, ia);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule